// File: doc/BRIEF.md
# Bandwidth Slot-Table Builder

This engine fills a fixed-length arbitration slot table from two inputs: a requested slot count for each client and a mask of active clients. The table decides which client owns each time slot of a memory arbiter. A single start pulse launches a run. The engine takes a copy of the counts and the mask, then works in two phases.

In the reservation phase, clients with a nonzero request are placed one after another at a stride that follows from their request. Slots that an earlier client already holds are stepped over. In the fill phase, the slots still empty are handed out round-robin among the active clients.

The fill phase sends every finished entry to a table write port, one entry per cycle, in ascending slot order. A one-cycle done pulse follows the last entry. The arbiter's table memory is written straight from that port.

Top module: `slot_table_builder`

## Requirements
- R1: After reset, `wr_en` and `done` are low and no write is issued until `start` is seen.
- R2: Reservation handles clients in ascending order 0 to 13. A client whose requested count is 0 reserves no slots. `req_cnt` bits [7*i+6:7*i] carry client i's count.
- R3: The stride of a reserving client is 64 divided by its count, with integer division. Placement begins at slot 0. A free slot is taken by the client, and the position then grows by the stride. An occupied slot moves the position on by 1. Placement ends once the position is 64 or more. A count above 64 gives stride 0, so the client takes every free slot from slot 0 upward.
- R4: Each slot left empty after reservation goes to the first client marked active in `active_mask` (bit i is client i), searching upward from a round-robin pointer with wrap from 13 to 0. The pointer is 0 at the start of the fill phase.
- R5: If no client is active, the empty slot goes to the client the pointer holds. After every fill-phase assignment, the pointer becomes the assigned client plus one, modulo 14.
- R6: Exactly 64 writes are issued, one per cycle, with `wr_idx` running from 0 to 63. `wr_val` always lies in 0 to 13.
- R7: `done` is high for exactly one cycle, in the cycle right after the write of slot 63, and never together with `wr_en`.
- R8: `req_cnt` and `active_mask` are sampled on the cycle `start` is accepted. A `start`, or a change of those inputs, arriving while a run is in progress has no effect on the table produced and starts no second run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launches a run when the engine is idle |
| req_cnt | input | 98 | Fourteen 7-bit requested slot counts, client 0 in the low bits |
| active_mask | input | 14 | Active flag for each client |
| wr_en | output | 1 | Table write strobe |
| wr_idx | output | 6 | Slot index being written |
| wr_val | output | 4 | Client number for that slot |
| done | output | 1 | One-cycle pulse after the final slot |

## Verification
The assertions assume that `start` is the only input that controls sequencing. They also assume that inputs the engine has already latched cannot change the run in progress. For that reason they check the write order, the value range, the timing of the done pulse and the round-robin choice, and they make no assumption about when `start` arrives.

The stimulus holds `start` for one cycle when the engine is idle. It also deliberately pulses `start` again in the middle of a run, with different inputs, to test the busy case. Request patterns cover overlapping strides, a full-table stride of 1, counts above 64, no active clients, and sparse active masks.

// File: rtl/slotgen_pkg.sv
package slotgen_pkg;

    typedef enum logic [1:0] {
        SG_IDLE    = 2'd0,
        SG_RESERVE = 2'd1,
        SG_FILL    = 2'd2,
        SG_FLUSH   = 2'd3
    } sg_state_e;

endpackage

// File: rtl/slot_stride.sv
module slot_stride #(
    parameter int NUM_SLOTS = 64,
    parameter int CNT_W     = 7,
    parameter int POS_W     = 7
) (
    input  logic [CNT_W-1:0] req,
    output logic [POS_W-1:0] stride
);

    localparam int QW = (CNT_W > POS_W) ? CNT_W + 1 : POS_W + 1;

    logic [QW-1:0] quot;

    always_comb begin
        if (req == '0) begin
            quot = '0;
        end else begin
            quot = QW'(NUM_SLOTS) / QW'(req);
        end
        stride = POS_W'(quot);
    end

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int NUM_CLIENTS = 14,
    parameter int CID_W       = 4
) (
    input  logic [NUM_CLIENTS-1:0] act,
    input  logic [CID_W-1:0]       ptr,
    output logic [CID_W-1:0]       pick,
    output logic                   found
);

    always_comb begin
        pick  = ptr;
        found = 1'b0;
        for (int k = 0; k < NUM_CLIENTS; k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= NUM_CLIENTS) begin
                idx = idx - NUM_CLIENTS;
            end
            if (!found && act[idx]) begin
                found = 1'b1;
                pick  = CID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/slot_table_builder.sv
module slot_table_builder
    import slotgen_pkg::*;
#(
    parameter int NUM_CLIENTS = 14,
    parameter int NUM_SLOTS   = 64,
    parameter int CNT_W       = 7
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic [NUM_CLIENTS*CNT_W-1:0]           req_cnt,
    input  logic [NUM_CLIENTS-1:0]                 active_mask,
    output logic                                   wr_en,
    output logic [$clog2(NUM_SLOTS)-1:0]           wr_idx,
    output logic [$clog2(NUM_CLIENTS+2)-1:0]       wr_val,
    output logic                                   done
);

    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int POS_W  = $clog2(2 * NUM_SLOTS);
    localparam int CID_W  = $clog2(NUM_CLIENTS);
    localparam int VAL_W  = $clog2(NUM_CLIENTS + 2);
    localparam logic [VAL_W-1:0] EMPTY = VAL_W'(NUM_CLIENTS + 1);

    typedef struct packed {
        sg_state_e                             st;
        logic [CID_W-1:0]                      cli;
        logic [POS_W-1:0]                      pos;
        logic [SLOT_W-1:0]                     slot;
        logic [CID_W-1:0]                      ptr;
        logic [NUM_SLOTS-1:0][VAL_W-1:0]       tbl;
        logic [NUM_CLIENTS-1:0][CNT_W-1:0]     req;
        logic [NUM_CLIENTS-1:0]                act;
        logic                                  wr_en;
        logic [SLOT_W-1:0]                     wr_idx;
        logic [VAL_W-1:0]                      wr_val;
        logic                                  done;
    } sg_reg_t;

    sg_reg_t q, d;

    logic [CNT_W-1:0] cur_req;
    logic [POS_W-1:0] cur_stride;
    logic [CID_W-1:0] rr_sel;
    logic             rr_found;
    logic [SLOT_W-1:0] pos_slot;

    assign cur_req  = q.req[q.cli];
    assign pos_slot = q.pos[SLOT_W-1:0];

    slot_stride #(
        .NUM_SLOTS (NUM_SLOTS),
        .CNT_W     (CNT_W),
        .POS_W     (POS_W)
    ) u_stride (
        .req    (cur_req),
        .stride (cur_stride)
    );

    rr_pick #(
        .NUM_CLIENTS (NUM_CLIENTS),
        .CID_W       (CID_W)
    ) u_rr (
        .act   (q.act),
        .ptr   (q.ptr),
        .pick  (rr_sel),
        .found (rr_found)
    );

    always_comb begin
        logic [VAL_W-1:0] fill_val;
        d        = q;
        d.wr_en  = 1'b0;
        d.done   = 1'b0;
        fill_val = q.tbl[q.slot];
        case (q.st)
            SG_IDLE: begin
                if (start) begin
                    d.st   = SG_RESERVE;
                    d.cli  = '0;
                    d.pos  = '0;
                    d.slot = '0;
                    d.ptr  = '0;
                    d.req  = req_cnt;
                    d.act  = active_mask;
                    for (int s = 0; s < NUM_SLOTS; s++) begin
                        d.tbl[s] = EMPTY;
                    end
                end
            end
            SG_RESERVE: begin
                if (cur_req == '0 || q.pos >= POS_W'(NUM_SLOTS)) begin
                    d.pos = '0;
                    if (q.cli == CID_W'(NUM_CLIENTS - 1)) begin
                        d.st = SG_FILL;
                    end else begin
                        d.cli = q.cli + 1'b1;
                    end
                end else if (q.tbl[pos_slot] == EMPTY) begin
                    d.tbl[pos_slot] = VAL_W'(q.cli);
                    d.pos           = q.pos + cur_stride;
                end else begin
                    d.pos = q.pos + 1'b1;
                end
            end
            SG_FILL: begin
                if (fill_val == EMPTY) begin
                    fill_val = VAL_W'(rr_sel);
                    d.ptr    = (rr_sel == CID_W'(NUM_CLIENTS - 1)) ? '0 : rr_sel + 1'b1;
                end
                d.tbl[q.slot] = fill_val;
                d.wr_en       = 1'b1;
                d.wr_idx      = q.slot;
                d.wr_val      = fill_val;
                if (q.slot == SLOT_W'(NUM_SLOTS - 1)) begin
                    d.st = SG_FLUSH;
                end else begin
                    d.slot = q.slot + 1'b1;
                end
            end
            default: begin
                d.done = 1'b1;
                d.st   = SG_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_en  = q.wr_en;
    assign wr_idx = q.wr_idx;
    assign wr_val = q.wr_val;
    assign done   = q.done;

    AST_VAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_val < VAL_W'(NUM_CLIENTS)));  // R6

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != '0) |-> ($past(wr_en) && wr_idx == $past(wr_idx) + 1'b1));  // R6

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && $past(wr_idx) == SLOT_W'(NUM_SLOTS - 1)));  // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R7

    AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && wr_en));  // R7

    AST_RR_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SG_FILL && q.tbl[q.slot] == EMPTY && (|q.act)) |-> q.act[rr_sel]);  // R4

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != SG_IDLE && start) |=> ($stable(q.req) && $stable(q.act)));  // R8

endmodule

// File: tb/slot_table_builder_bench.sv
`timescale 1ns/1ps
module slot_table_builder_bench;

    localparam int NC = 14;
    localparam int NS = 64;
    localparam int CW = 7;
    localparam int NV = 6;

    localparam int V_CA  [NV] = '{0, 0, 0, 5, 2, 7};
    localparam int V_NA  [NV] = '{0, 0, 4, 3, 100, 5};
    localparam int V_CB  [NV] = '{0, 0, 3, 13, 0, 1};
    localparam int V_NB  [NV] = '{0, 0, 8, 64, 0, 6};
    localparam logic [NC-1:0] V_ACT [NV] = '{14'h0000, 14'h0C00, 14'h0029,
                                             14'h3FFF, 14'h0000, 14'h2082};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [NC*CW-1:0]  req_cnt = '0;
    logic [NC-1:0]     active_mask = '0;
    logic              wr_en;
    logic [5:0]        wr_idx;
    logic [3:0]        wr_val;
    logic              done;

    int n_checks = 0;
    int n_fails  = 0;
    int wr_cnt   = 0;
    int done_cnt = 0;
    int cycles   = 0;
    int got [NS];
    int expv [NS];

    always #2.5 clk = ~clk;

    slot_table_builder u_slot_table_builder (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .req_cnt     (req_cnt),
        .active_mask (active_mask),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_val      (wr_val),
        .done        (done)
    );

    task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
        if (rst_n && wr_en) begin
            check(int'(wr_idx) == wr_cnt, "R6 write order", int'(wr_idx), wr_cnt);
            got[wr_idx] = int'(wr_val);
            wr_cnt++;
        end
        if (rst_n && done) begin
            check(wr_cnt == NS, "R7 done after last write", wr_cnt, NS);
            done_cnt++;
        end
    end

    function automatic logic [NC*CW-1:0] make_req(input int ca, input int na,
                                                 input int cb, input int nb);
        logic [NC*CW-1:0] r;
        r = '0;
        r[ca*CW +: CW] = CW'(na);
        r[cb*CW +: CW] = CW'(nb);
        return r;
    endfunction

    // Reference model written from R2..R5
    task automatic model(input logic [NC*CW-1:0] r, input logic [NC-1:0] a);
        int p;
        int ptr;
        for (int s = 0; s < NS; s++) expv[s] = NC + 1;
        for (int c = 0; c < NC; c++) begin
            int n;
            int st;
            n = int'(r[c*CW +: CW]);
            if (n == 0) continue;
            st = NS / n;
            p = 0;
            while (p < NS) begin
                if (expv[p] != NC + 1) p++;
                else begin
                    expv[p] = c;
                    p += st;
                end
            end
        end
        ptr = 0;
        for (int s = 0; s < NS; s++) begin
            if (expv[s] == NC + 1) begin
                int first;
                first = ptr;
                while (!a[ptr]) begin
                    ptr = (ptr + 1) % NC;
                    if (ptr == first) break;
                end
                expv[s] = ptr;
                ptr = (ptr + 1) % NC;
            end
        end
    endtask

    task automatic wait_done();
        int k;
        k = 0;
        while (done_cnt == 0 && k < 4000) begin
            @(negedge clk);
            k++;
        end
        check(done_cnt == 1, "R7 done seen once", done_cnt, 1);
        repeat (3) @(negedge clk);
        check(done_cnt == 1, "R7 done single pulse", done_cnt, 1);
    endtask

    task automatic compare_table(input string tag);
        check(wr_cnt == NS, "R6 write count", wr_cnt, NS);
        for (int s = 0; s < NS; s++) begin
            check(got[s] == expv[s], tag, got[s], expv[s]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(wr_en == 1'b0, "R1 wr_en in reset", int'(wr_en), 0);
        check(done == 1'b0, "R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(wr_cnt == 0, "R1 no write before start", wr_cnt, 0);
        check(done == 1'b0, "R1 done idle", int'(done), 0);

        // Table-driven runs: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            logic [NC*CW-1:0] r;
            r = make_req(V_CA[v], V_NA[v], V_CB[v], V_NB[v]);
            model(r, V_ACT[v]);
            wr_cnt = 0;
            done_cnt = 0;
            for (int s = 0; s < NS; s++) got[s] = -1;
            req_cnt = r;
            active_mask = V_ACT[v];
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done();
            compare_table("R2 R3 R4 R5 slot value");
        end

        // R8: start and input changes while busy are ignored
        begin
            logic [NC*CW-1:0] r;
            r = make_req(0, 4, 3, 8);
            model(r, 14'h0029);
            wr_cnt = 0;
            done_cnt = 0;
            for (int s = 0; s < NS; s++) got[s] = -1;
            req_cnt = r;
            active_mask = 14'h0029;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (10) @(negedge clk);
            req_cnt = make_req(6, 2, 9, 16);
            active_mask = 14'h1111;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done();
            compare_table("R8 busy start ignored");
            repeat (200) @(negedge clk);
            check(wr_cnt == NS, "R8 no second run", wr_cnt, NS);
            check(done_cnt == 1, "R8 no second done", done_cnt, 1);
        end

        finish_run();
    end

endmodule